// File: doc/BRIEF.md
# Double-Buffered Compare Register Update for a Complementary PWM Timer

This block holds the five timing values a three-phase complementary PWM timer compares against: the counter upper limit, the carrier half period, and one duty compare value per phase. Each value passes through three stages: a buffer that software writes, a hidden staging register, and the active register that the counters use. A write to the third phase's duty buffer is the arming write. It copies all five buffers into the staging registers at once. The staged set then moves into the active registers at the next enabled turning point of the counter, which is its crest or its trough.

Software therefore updates any subset of the values and writes the third duty buffer last, even when that value is unchanged. The active set seen by the counters always changes as a whole and only at a turning point. While the timer is halted, writes load the buffer and the active register together so that initialization takes effect at once. The commit-point selection is sampled only while halted.

Top module: `pwm_shadow_regs`

## Requirements
- R1: After reset all five active registers read zero and the commit mode enables both crest and trough.
- R2: Register addresses are 0 upper limit, 1 half period, 2 duty phase A, 3 duty phase B, 4 duty phase C. While `run` is low, a write to address k loads buffer k and active register k together, and the active output shows the data one cycle later.
- R3: While `run` is high, writes to addresses 0 to 3 change only the buffers. The active outputs do not change.
- R4: While `run` is high, a write to address 4 arms a transfer. It copies all five buffers, including the new address-4 data, into the staging registers, and the active outputs stay unchanged until a commit.
- R5: An armed transfer commits at the first cycle with an enabled crest or trough pulse. All five active outputs take the staged values on the following cycle.
- R6: One arming write gives exactly one commit. Later crest or trough pulses leave the active outputs unchanged until the next arming write.
- R7: Buffer writes made after arming and before the commit do not alter the values that commit.
- R8: Bit 0 of `mode_sel` enables commit at a crest and bit 1 enables commit at a trough. A pulse whose bit is clear does not commit.
- R9: `mode_sel` is sampled only while `run` is low. Changes made while running have no effect.
- R10: Writes to addresses 5 to 7 change nothing.
- R11: If an arming write and an enabled pulse fall in the same cycle while already armed, the previous staged set commits and the new set stays pending.
- R12: Pulses while `run` is low do nothing, and dropping `run` discards a pending transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | High while the timer counters are counting |
| mode_sel | input | 2 | Commit-point select: bit 0 crest, bit 1 trough |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| crest | input | 1 | Single-cycle pulse at the counter crest |
| trough | input | 1 | Single-cycle pulse at the counter trough |
| act_top | output | DATA_W | Active upper limit |
| act_half | output | DATA_W | Active half period |
| act_duty_a | output | DATA_W | Active duty compare, phase A |
| act_duty_b | output | DATA_W | Active duty compare, phase B |
| act_duty_c | output | DATA_W | Active duty compare, phase C |

## Verification
The bench builds the block with DATA_W set to 12 and ADDR_W left at 3. The narrow data width lets random data reach all-zero and all-ones values often. The three-bit address reaches the unused codes 5 to 7, so ignored writes are exercised. Random sequences mix running and halted phases, every mode value, and pulses that coincide with arming writes, which brings the same-cycle commit-and-rearm case within reach.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
    localparam int NUM_SLOTS = 5;
    localparam int ARM_SLOT  = 4;   // third phase duty buffer arms the transfer
    localparam logic [1:0] MODE_RESET = 2'b11;
endpackage

// File: rtl/shadow_slot.sv
module shadow_slot #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_wr,
    input  logic              direct_ld,
    input  logic              capture,
    input  logic              commit,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] act
);
    typedef struct packed {
        logic [DATA_W-1:0] bufv;
        logic [DATA_W-1:0] stg;
        logic [DATA_W-1:0] act;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (buf_wr) s_d.bufv = wr_data;
        if (capture) s_d.stg = s_d.bufv;
        if (commit) s_d.act = s_q.stg;
        if (direct_ld) s_d.act = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act = s_q.act;
endmodule

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
    import pwm_shadow_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [1:0]           mode_sel,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic                 crest,
    input  logic                 trough,
    output logic [NUM_SLOTS-1:0] slot_wr,
    output logic                 direct_ld,
    output logic                 capture,
    output logic                 commit,
    output logic [1:0]           mode_q,
    output logic                 armed_q
);
    typedef struct packed {
        logic [1:0] mode;
        logic       armed;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++)
            slot_wr[i] = wr_en && (wr_addr == ADDR_W'(i));
        direct_ld = !run;
        capture   = run && slot_wr[ARM_SLOT];
        commit    = run && c_q.armed &&
                    ((crest && c_q.mode[0]) || (trough && c_q.mode[1]));

        c_d = c_q;
        if (!run)         c_d.mode = mode_sel;
        if (!run)         c_d.armed = 1'b0;
        else if (capture) c_d.armed = 1'b1;
        else if (commit)  c_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{mode: MODE_RESET, armed: 1'b0};
        else        c_q <= c_d;
    end

    assign mode_q  = c_q.mode;
    assign armed_q = c_q.armed;
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_shadow_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [1:0]        mode_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              crest,
    input  logic              trough,
    output logic [DATA_W-1:0] act_top,
    output logic [DATA_W-1:0] act_half,
    output logic [DATA_W-1:0] act_duty_a,
    output logic [DATA_W-1:0] act_duty_b,
    output logic [DATA_W-1:0] act_duty_c
);
    logic [NUM_SLOTS-1:0] slot_wr;
    logic                 direct_ld, capture, commit, armed_q;
    logic [1:0]           mode_q;
    logic [DATA_W-1:0]    act_v [NUM_SLOTS];

    shadow_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .crest(crest), .trough(trough),
        .slot_wr(slot_wr), .direct_ld(direct_ld), .capture(capture),
        .commit(commit), .mode_q(mode_q), .armed_q(armed_q)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        shadow_slot #(.DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .buf_wr(slot_wr[g]),
            .direct_ld(direct_ld && slot_wr[g]),
            .capture(capture), .commit(commit),
            .wr_data(wr_data), .act(act_v[g])
        );
    end

    assign act_top    = act_v[0];
    assign act_half   = act_v[1];
    assign act_duty_a = act_v[2];
    assign act_duty_b = act_v[3];
    assign act_duty_c = act_v[4];
endmodule

// File: rtl/pwm_shadow_chk.sv
module pwm_shadow_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              crest,
    input logic              trough,
    input logic [1:0]        mode_q,
    input logic              armed_q,
    input logic [DATA_W-1:0] act_top,
    input logic [DATA_W-1:0] act_half,
    input logic [DATA_W-1:0] act_duty_a,
    input logic [DATA_W-1:0] act_duty_b,
    input logic [DATA_W-1:0] act_duty_c
);
    logic [5*DATA_W-1:0] all_act;
    assign all_act = {act_top, act_half, act_duty_a, act_duty_b, act_duty_c};

    assert_no_pulse_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !crest && !trough) |=> $stable(all_act));

    assert_halted_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && wr_en && wr_addr == ADDR_W'(4)) |=> act_duty_c == $past(wr_data));

    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(mode_q));

    assert_single_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !armed_q) |=> $stable(all_act));

    assert_halt_discards_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !armed_q);
endmodule

bind pwm_shadow_regs pwm_shadow_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .crest(crest), .trough(trough), .mode_q(mode_q),
    .armed_q(armed_q), .act_top(act_top), .act_half(act_half),
    .act_duty_a(act_duty_a), .act_duty_b(act_duty_b), .act_duty_c(act_duty_c)
);

// File: tb/pwm_shadow_regs_tb.sv
module pwm_shadow_regs_tb;
    localparam int DW = 12;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic [1:0]    mode_sel = 2'b11;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          crest = 1'b0, trough = 1'b0;
    logic [DW-1:0] act_top, act_half, act_duty_a, act_duty_b, act_duty_c;

    int n_vec = 0, n_bad = 0;

    // expected-value state
    logic [DW-1:0] m_buf [5];
    logic [DW-1:0] m_stg [5];
    logic [DW-1:0] m_act [5];
    logic          m_armed;
    logic [1:0]    m_mode;

    always #4 clk = ~clk;

    pwm_shadow_regs #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .mode_sel(mode_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .crest(crest), .trough(trough),
        .act_top(act_top), .act_half(act_half), .act_duty_a(act_duty_a),
        .act_duty_b(act_duty_b), .act_duty_c(act_duty_c)
    );

    function automatic logic [DW-1:0] dut_act(int i);
        case (i)
            0: return act_top;
            1: return act_half;
            2: return act_duty_a;
            3: return act_duty_b;
            default: return act_duty_c;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 5; i++) begin
            m_buf[i] = '0; m_stg[i] = '0; m_act[i] = '0;
        end
        m_armed = 1'b0;
        m_mode  = 2'b11;
    endtask

    task automatic model_step();
        logic fire;
        logic wr_ok;
        fire  = run && m_armed && ((crest && m_mode[0]) || (trough && m_mode[1]));
        wr_ok = wr_en && (wr_addr < 5);
        if (fire)
            for (int i = 0; i < 5; i++) m_act[i] = m_stg[i];
        if (wr_ok) begin
            m_buf[wr_addr] = wr_data;
            if (!run) m_act[wr_addr] = wr_data;
        end
        if (!run) begin
            m_armed = 1'b0;
            m_mode  = mode_sel;
        end else if (wr_ok && wr_addr == 4) begin
            for (int i = 0; i < 5; i++) m_stg[i] = m_buf[i];
            m_armed = 1'b1;
        end else if (fire) begin
            m_armed = 1'b0;
        end
    endtask

    task automatic check_all(string tag);
        for (int i = 0; i < 5; i++) begin
            n_vec++;
            if (dut_act(i) !== m_act[i]) begin
                n_bad++;
                $display("FAIL %s slot %0d actual %0h expected %0h", tag, i, dut_act(i), m_act[i]);
            end
        end
    endtask

    task automatic cyc(input logic r, input logic [1:0] m, input logic we,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic cr, input logic tr, input string tag);
        run = r; mode_sel = m; wr_en = we; wr_addr = a; wr_data = d;
        crest = cr; trough = tr;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic expect_val(int i, logic [DW-1:0] v, string tag);
        n_vec++;
        if (dut_act(i) !== v) begin
            n_bad++;
            $display("FAIL %s slot %0d actual %0h expected %0h", tag, i, dut_act(i), v);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 17;
        void'($urandom(seed));
        model_reset();
        repeat (2) @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: halted initialization loads buffer and active together
        for (int i = 0; i < 5; i++)
            cyc(0, 2'b11, 1, AW'(i), DW'(12'h100 + i), 0, 0, "R2 halted load");
        expect_val(4, 12'h104, "R2 direct value");
        // R10: unused addresses
        cyc(0, 2'b11, 1, 3'd6, 12'hFFF, 0, 0, "R10 unused addr");
        // R12: pulses while halted
        cyc(0, 2'b11, 0, 0, 0, 1, 1, "R12 halted pulses");

        // R3 / R4 / R5 / R6
        cyc(1, 2'b11, 1, 3'd0, 12'hA00, 0, 0, "R3 running write");
        cyc(1, 2'b11, 1, 3'd2, 12'hA02, 0, 0, "R3 running write");
        expect_val(0, 12'h100, "R3 active unchanged");
        cyc(1, 2'b11, 1, 3'd4, 12'hA04, 0, 0, "R4 arming");
        expect_val(4, 12'h104, "R4 active held");
        cyc(1, 2'b11, 1, 3'd3, 12'hBBB, 0, 0, "R7 late write");
        cyc(1, 2'b11, 0, 0, 0, 1, 0, "R5 commit at crest");
        expect_val(0, 12'hA00, "R5 top committed");
        expect_val(3, 12'h103, "R7 late write excluded");
        cyc(1, 2'b11, 0, 0, 0, 0, 1, "R6 no second commit");
        expect_val(3, 12'h103, "R6 held");

        // R8: crest-only mode ignores trough
        cyc(0, 2'b01, 0, 0, 0, 0, 0, "R8 set mode");
        cyc(1, 2'b01, 1, 3'd4, 12'h444, 0, 0, "R8 arm");
        cyc(1, 2'b10, 0, 0, 0, 0, 1, "R8 trough ignored");
        expect_val(4, 12'hA04, "R8 trough ignored");
        // R9: mode change while running ignored, crest still commits
        cyc(1, 2'b10, 0, 0, 0, 1, 0, "R9 crest commits");
        expect_val(4, 12'h444, "R9 crest commits");

        // R11: arming write coinciding with enabled pulse while armed
        cyc(1, 2'b10, 1, 3'd4, 12'h555, 0, 0, "R11 first arm");
        cyc(1, 2'b10, 1, 3'd4, 12'h666, 1, 0, "R11 commit and rearm");
        expect_val(4, 12'h555, "R11 old set committed");
        cyc(1, 2'b10, 0, 0, 0, 1, 0, "R11 pending commits");
        expect_val(4, 12'h666, "R11 new set committed");

        // R12: dropping run discards pending
        cyc(1, 2'b10, 1, 3'd4, 12'h777, 0, 0, "R12 arm");
        cyc(0, 2'b11, 0, 0, 0, 0, 0, "R12 halt");
        cyc(1, 2'b11, 0, 0, 0, 1, 1, "R12 discarded");
        expect_val(4, 12'h666, "R12 discarded");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic r;
            r = ($urandom % 16) != 0;
            cyc(r, 2'($urandom), ($urandom % 3) != 0, AW'($urandom),
                DW'($urandom), ($urandom % 5) == 0, ($urandom % 5) == 0,
                "R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule